// File: doc/BRIEF.md
# Configuration Header Word Parser

This block consumes the 32-bit words fetched from the start of a boot flash, one word per accepted valid/ready handshake. While hunting, it throws away every word that is not the synchronisation pattern 0xAA995566, which is normally all-ones padding. Once that pattern has been seen, each word is read as a register write. The upper 16 bits are the opcode and the lower 16 bits are the data. Four opcodes load the boot-address registers: two for the update image and two for the fallback (golden) image.

Parsing stops at the first word whose top nibble is neither 0x2 nor 0x3. That word marks the end of the header. If the sync pattern does not arrive within a programmable number of words, as happens with an erased flash, the parser reports an error instead. Both end conditions hold until reset. While in either end condition the parser stops taking words.

The decoded register values come out with one valid flag per register. A flag per image also shows when its stored read-opcode byte selects a single-bit-wide serial read.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After reset, ready_o is 1, synced_o, done_o and error_o are 0, reg_valid_o is 0 and all four register outputs are 0.
- R2: Before sync, each accepted 0xFFFFFFFF word is discarded: no register changes and synced_o stays 0.
- R3: An accepted 0xAA995566 word raises synced_o in the cycle after it. No word accepted before it is decoded, even one that looks like a register write.
- R4: After sync, a word with upper half 0x3261 loads its lower half into upd_lo_o (address bits [15:0]) and sets reg_valid_o[0].
- R5: After sync, upper half 0x3281 loads upd_hi_o (read-opcode byte in [15:8], address bits [23:16] in [7:0]) and sets reg_valid_o[1].
- R6: After sync, upper half 0x32A1 loads gold_lo_o and sets reg_valid_o[2]. Upper half 0x32C1 loads gold_hi_o and sets reg_valid_o[3].
- R7: A later write to a register overwrites its value, and its valid flag stays 1.
- R8: After sync, a word whose top nibble is 0x2 (for example the no-op pair 0x20002000) is skipped. So is a word with top nibble 0x3 that is not one of the four opcodes. Neither changes any output.
- R9: After sync, an accepted word whose top nibble is neither 0x2 nor 0x3 is consumed. In the next cycle done_o becomes 1 and ready_o becomes 0, while synced_o stays 1.
- R10: While hunting, once the number of accepted non-sync words reaches sync_limit_i, error_o becomes 1 and ready_o 0 in the next cycle, and synced_o stays 0. A limit of 0 acts as 1.
- R11: upd_spi_x1_o is 1 exactly when reg_valid_o[1] is 1 and upd_hi_o[15:8] is 0x03. gold_spi_x1_o follows the same rule for reg_valid_o[3] and gold_hi_o.
- R12: The done and error conditions last until reset, and later words change no output. A cycle with valid_i low consumes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | 32 | Flash word |
| valid_i | input | 1 | word_i is valid |
| ready_o | output | 1 | Parser accepts a word this cycle |
| sync_limit_i | input | LIMIT_W | Non-sync words allowed before error |
| upd_lo_o | output | 16 | Update image address [15:0] |
| upd_hi_o | output | 16 | Update image read opcode and address [23:16] |
| gold_lo_o | output | 16 | Golden image address [15:0] |
| gold_hi_o | output | 16 | Golden image read opcode and address [23:16] |
| reg_valid_o | output | 4 | Per-register written flags (upd_lo, upd_hi, gold_lo, gold_hi) |
| upd_spi_x1_o | output | 1 | Update image uses single-bit serial read |
| gold_spi_x1_o | output | 1 | Golden image uses single-bit serial read |
| synced_o | output | 1 | Sync word seen |
| done_o | output | 1 | Header terminated |
| error_o | output | 1 | Sync limit exhausted |

## Verification
A wrong parser state shows up at the ports one cycle after the word that caused it. A hunt state that fails to leave on sync leaves synced_o low. A hunt state left too early shows a register valid flag while synced_o is still 0. An end state that is not sticky brings ready_o back high, and a later word then changes a register. A miscounted sync limit moves the rise of error_o by one or more words, and the pad sequence around the limit boundary detects this.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned NREG   = 4;

  localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA99_5566;
  localparam logic [7:0]        RD_X1_OPC = 8'h03;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_PARSE = 2'd1,
    ST_DONE  = 2'd2,
    ST_ERR   = 2'd3
  } pstate_e;

  // register index -> write opcode (upper half of word)
  function automatic logic [HALF_W-1:0] reg_opc(input int unsigned idx);
    case (idx)
      0:       reg_opc = 16'h3261;
      1:       reg_opc = 16'h3281;
      2:       reg_opc = 16'h32A1;
      default: reg_opc = 16'h32C1;
    endcase
  endfunction
endpackage

// File: rtl/cfg_word_class.sv
module cfg_word_class
  import cfg_hdr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              is_sync_o,
  output logic              is_end_o,
  output logic [NREG-1:0]   wr_oh_o
);
  logic [3:0] top_nib;
  assign top_nib   = word_i[WORD_W-1 -: 4];
  assign is_sync_o = (word_i == SYNC_WORD);
  assign is_end_o  = (top_nib != 4'h2) && (top_nib != 4'h3);

  for (genvar g = 0; g < NREG; g++) begin : g_opc
    assign wr_oh_o[g] = (word_i[WORD_W-1 -: HALF_W] == reg_opc(g));
  end
endmodule

// File: rtl/cfg_hunt_fsm.sv
module cfg_hunt_fsm
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               is_sync_i,
  input  logic               is_end_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output pstate_e            state_o
);
  pstate_e            state_q, state_d;
  logic [LIMIT_W-1:0] cnt_q, cnt_d;
  logic [LIMIT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_HUNT: if (fire_i) begin
        if (is_sync_i)                        state_d = ST_PARSE;
        else if (cnt_inc >= {1'b0, limit_i})  state_d = ST_ERR;
        else                                  cnt_d   = cnt_inc[LIMIT_W-1:0];
      end
      ST_PARSE: if (fire_i && is_end_i) state_d = ST_DONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  p_sync_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT && state_d == ST_PARSE) |-> (fire_i && is_sync_i));
  p_err_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT) |=> (state_q != ST_ERR || $past(fire_i && !is_sync_i)));
  p_done_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_DONE));
  p_err_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR) |=> (state_q == ST_ERR));
endmodule

// File: rtl/cfg_addr_bank.sv
module cfg_addr_bank
  import cfg_hdr_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NREG-1:0]              we_i,
  input  logic [HALF_W-1:0]            din_i,
  output logic [NREG-1:0][HALF_W-1:0]  data_o,
  output logic [NREG-1:0]              vld_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[g] <= '0;
        vld_o[g]  <= 1'b0;
      end else if (we_i[g]) begin
        data_o[g] <= din_i;
        vld_o[g]  <= 1'b1;
      end
    end

    p_valid_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o[g] |=> vld_o[g]);
  end

  p_one_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_i));
endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        word_i,
  input  logic               valid_i,
  output logic               ready_o,
  input  logic [LIMIT_W-1:0] sync_limit_i,
  output logic [15:0]        upd_lo_o,
  output logic [15:0]        upd_hi_o,
  output logic [15:0]        gold_lo_o,
  output logic [15:0]        gold_hi_o,
  output logic [3:0]         reg_valid_o,
  output logic               upd_spi_x1_o,
  output logic               gold_spi_x1_o,
  output logic               synced_o,
  output logic               done_o,
  output logic               error_o
);
  pstate_e                      state;
  logic                         fire, is_sync, is_end;
  logic [NREG-1:0]              wr_oh, we;
  logic [NREG-1:0][HALF_W-1:0]  regs;

  assign ready_o = (state == ST_HUNT) || (state == ST_PARSE);
  assign fire    = valid_i && ready_o;

  cfg_word_class u_class (
    .word_i    (word_i),
    .is_sync_o (is_sync),
    .is_end_o  (is_end),
    .wr_oh_o   (wr_oh)
  );

  cfg_hunt_fsm #(.LIMIT_W(LIMIT_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .is_sync_i (is_sync),
    .is_end_i  (is_end),
    .limit_i   (sync_limit_i),
    .state_o   (state)
  );

  assign we = (fire && state == ST_PARSE) ? wr_oh : '0;

  cfg_addr_bank u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .din_i  (word_i[HALF_W-1:0]),
    .data_o (regs),
    .vld_o  (reg_valid_o)
  );

  assign upd_lo_o  = regs[0];
  assign upd_hi_o  = regs[1];
  assign gold_lo_o = regs[2];
  assign gold_hi_o = regs[3];

  assign upd_spi_x1_o  = reg_valid_o[1] && (regs[1][15:8] == RD_X1_OPC);
  assign gold_spi_x1_o = reg_valid_o[3] && (regs[3][15:8] == RD_X1_OPC);

  assign synced_o = (state == ST_PARSE) || (state == ST_DONE);
  assign done_o   = (state == ST_DONE);
  assign error_o  = (state == ST_ERR);

  p_no_wr_unsynced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_o |-> (reg_valid_o == '0));
  p_err_unsynced_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !synced_o);
  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ready_o) |=> $stable({upd_lo_o, upd_hi_o, gold_lo_o, gold_hi_o, reg_valid_o}));
  p_end_no_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) |-> !ready_o);
endmodule

// File: tb/cfg_hdr_parser_tb.sv
module cfg_hdr_parser_tb;
  localparam int unsigned LIMIT_W = 16;
  localparam time CLK_P = 20ns;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [31:0]        word = '0;
  logic               valid = 1'b0;
  logic [LIMIT_W-1:0] limit = 16'd8;
  logic               ready_o, upd_spi_x1_o, gold_spi_x1_o, synced_o, done_o, error_o;
  logic [15:0]        upd_lo_o, upd_hi_o, gold_lo_o, gold_hi_o;
  logic [3:0]         reg_valid_o;
  int                 n_checks = 0;
  int                 n_errors = 0;

  always #(CLK_P/2) clk = ~clk;

  cfg_hdr_parser #(.LIMIT_W(LIMIT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word), .valid_i(valid), .ready_o(ready_o),
    .sync_limit_i(limit), .upd_lo_o(upd_lo_o), .upd_hi_o(upd_hi_o),
    .gold_lo_o(gold_lo_o), .gold_hi_o(gold_hi_o), .reg_valid_o(reg_valid_o),
    .upd_spi_x1_o(upd_spi_x1_o), .gold_spi_x1_o(gold_spi_x1_o),
    .synced_o(synced_o), .done_o(done_o), .error_o(error_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [LIMIT_W-1:0] lim);
    @(negedge clk);
    rst_ni = 1'b0; valid = 1'b0; limit = lim;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    word = w; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(16'd8);
    chk("R1", "ready", ready_o, 1);
    chk("R1", "flags", {synced_o, done_o, error_o}, 0);
    chk("R1", "reg_valid", reg_valid_o, 0);
    chk("R1", "regs", upd_lo_o | upd_hi_o | gold_lo_o | gold_hi_o, 0);
  endtask

  task automatic t_hunt;
    send(32'hFFFF_FFFF);
    send(32'hFFFF_FFFF);
    chk("R2", "synced after pad", synced_o, 0);
    chk("R2", "reg_valid after pad", reg_valid_o, 0);
    send(32'h3261_BEEF);
    chk("R3", "pre-sync write not decoded", {reg_valid_o, upd_lo_o}, 0);
    send(32'hAA99_5566);
    chk("R3", "synced", synced_o, 1);
    chk("R3", "ready", ready_o, 1);
  endtask

  task automatic t_decode;
    send(32'h31E1_FFFF);
    chk("R8", "unknown 0x3 ignored", reg_valid_o, 0);
    send(32'h3261_1234);
    chk("R4", "upd_lo", upd_lo_o, 32'h1234);
    chk("R4", "valid", reg_valid_o, 4'b0001);
    send(32'h3281_0340);
    chk("R5", "upd_hi", upd_hi_o, 32'h0340);
    chk("R5", "valid", reg_valid_o, 4'b0011);
    chk("R11", "upd x1", upd_spi_x1_o, 1);
    chk("R11", "gold x1 unwritten", gold_spi_x1_o, 0);
    send(32'h32A1_5678);
    chk("R6", "gold_lo", gold_lo_o, 32'h5678);
    send(32'h32C1_0401);
    chk("R6", "gold_hi", gold_hi_o, 32'h0401);
    chk("R6", "valid", reg_valid_o, 4'b1111);
    chk("R11", "gold opcode 0x04", gold_spi_x1_o, 0);
    send(32'h2000_2000);
    chk("R8", "nop regs", {upd_lo_o, upd_hi_o, gold_lo_o, gold_hi_o}, 64'h1234_0340_5678_0401);
    chk("R8", "nop state", {synced_o, done_o, ready_o}, 3'b101);
    send(32'h30A1_0000);
    chk("R8", "unknown write regs", {upd_lo_o, upd_hi_o}, 32'h1234_0340);
  endtask

  task automatic t_overwrite;
    send(32'h32C1_0301);
    chk("R7", "gold_hi rewritten", gold_hi_o, 32'h0301);
    chk("R11", "gold x1", gold_spi_x1_o, 1);
    send(32'h3261_1111);
    chk("R7", "upd_lo rewritten", upd_lo_o, 32'h1111);
    chk("R7", "valid kept", reg_valid_o, 4'b1111);
  endtask

  task automatic t_idle_and_end;
    @(negedge clk);
    word = 32'h3261_0BAD; valid = 1'b0;
    @(negedge clk);
    chk("R12", "valid low no consume", upd_lo_o, 32'h1111);
    send(32'h0000_000E);
    chk("R9", "done", done_o, 1);
    chk("R9", "ready low", ready_o, 0);
    chk("R9", "synced kept", synced_o, 1);
    send(32'h3261_9999);
    chk("R12", "no write after done", upd_lo_o, 32'h1111);
    send(32'hAA99_5566);
    chk("R12", "done sticky", {done_o, error_o, synced_o}, 3'b101);
  endtask

  task automatic t_limit;
    do_reset(16'd4);
    for (int i = 0; i < 3; i++) send(32'hFFFF_FFFF);
    chk("R10", "no error before limit", {error_o, ready_o}, 2'b01);
    send(32'hFFFF_FFFF);
    chk("R10", "error at limit", error_o, 1);
    chk("R10", "ready low", ready_o, 0);
    send(32'hAA99_5566);
    chk("R10", "unsynced after error", synced_o, 0);
    chk("R12", "error sticky", error_o, 1);
    // sync one word before the limit still succeeds
    do_reset(16'd4);
    for (int i = 0; i < 3; i++) send(32'hFFFF_FFFF);
    send(32'hAA99_5566);
    chk("R10", "sync just inside limit", {synced_o, error_o}, 2'b10);
    // limit 0 behaves as 1
    do_reset(16'd0);
    send(32'hFFFF_FFFF);
    chk("R10", "limit zero", error_o, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    t_reset();
    t_hunt();
    t_decode();
    t_overwrite();
    t_idle_and_end();
    t_limit();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule